// File: doc/BRIEF.md
# RGB Panel Video Timing Generator

This block produces the dot-clock-domain video timing for a 176 x 220 pixel RGB panel fed over an 18-bit parallel bus. It runs a horizontal counter over a fixed 196-clock line and a vertical counter over a fixed 224-line frame. From those two counts it derives active-low horizontal and vertical sync, a data-qualifying enable, and the pixel bus. The pixel bus carries 6 bits of red, 6 of green and 6 of blue.

Pixel words come from an upstream source through a ready/valid pair. The generator raises `src_ready` on every clock that falls inside the active picture, and it passes the offered word through only when the source marks it valid. The number of dummy lines between the vertical sync line and the first visible line is programmable. That setting is sampled only at frame boundaries, so a frame never changes shape partway through. Both counters are brought out so that neighbouring logic, such as a test-pattern source, can key on the raster position.

Top module: `lcd_rgb_timing`

## Requirements
- R1: `h_count` steps by one on every clock from 0 to 195 and then returns to 0. `v_count` steps by one only on the clock where `h_count` returns from 195 to 0. It runs from 0 to 223 and then returns to 0.
- R2: `hsync_n` is low exactly while `h_count` is 0, which is one clock per line.
- R3: `vsync_n` is low for the whole of line 0, which is all 196 clocks where `v_count` is 0, and high on every other line.
- R4: The horizontal active window is `h_count` 10 to 185 inclusive, which is 176 clocks. Clocks 0 to 9 (back porch) and 186 to 195 (front porch) are never active.
- R5: A line is active when `v_count` lies in the range from B to B+219, limited to lines 0 to 223, where B is the latched back-porch value. With B = 3 the active lines are 3 to 222. With B = 0, line 0 is active. With B at or above 224, no line is active.
- R6: `vbp_cfg` is latched into B on a reset clock and on the clock where the frame wraps from line 223 to line 0. A change to `vbp_cfg` at any other time has no effect on the current frame.
- R7: `enable` is high exactly when the horizontal and vertical windows are both active. `src_ready` equals `enable`.
- R8: `pix_data` equals `src_data` when `enable` and `src_valid` are both high, and is zero otherwise. Bits 17:12 are red, bits 11:6 are green and bits 5:0 are blue.
- R9: When `rst` is high at a clock edge, both counters go to 0. This places the raster at the start of the vertical sync line, with `hsync_n` and `vsync_n` low and `enable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| vbp_cfg | input | 8 | Vertical back porch in lines, latched at frame wrap |
| src_valid | input | 1 | Upstream word on `src_data` is valid |
| src_data | input | 18 | Upstream pixel word, R[17:12] G[11:6] B[5:0] |
| src_ready | output | 1 | Generator takes a pixel this clock |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| enable | output | 1 | Pixel bus holds valid display data |
| pix_data | output | 18 | Pixel bus to the panel |
| h_count | output | 8 | Horizontal position within the line |
| v_count | output | 8 | Vertical position within the frame |

## Verification
The bench follows every clock of more than three complete frames against its own raster model. It goes after the window edges at clocks 9/10 and 185/186, the last-line wrap, and a back porch of zero. A generator that is off by one at any of these edges shows up as a shifted `enable` or a 175- or 177-clock active line.

Partway through a frame, the bench changes the back-porch input. It does this once to a value past the end of the frame and once to a value that clips the active region. A design that samples this input continuously would move the active lines mid-frame, and the per-frame count of enabled clocks would no longer be 38720, 0 or 37664.

The bench also drops `src_valid` in a fixed pattern to catch a gate that ignores it. Finally, it applies a reset in the middle of a line, which a generator whose reset is not synchronous would mishandle.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

  // Width needed to hold values 0 .. n-1
  function automatic int ctr_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // True when pos lies in [start, start+len)
  function automatic logic in_span(input int pos, input int start, input int len);
    return (pos >= start) && (pos < start + len);
  endfunction

endpackage

// File: rtl/lcd_wrap_ctr.sv
module lcd_wrap_ctr #(
  parameter int LIMIT = 196,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign wrap = inc && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= wrap ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/lcd_pixel_gate.sv
module lcd_pixel_gate #(
  parameter int PW = 18
) (
  input  logic          enable,
  input  logic          src_valid,
  input  logic [PW-1:0] src_data,
  output logic [PW-1:0] pix_data
);
  assign pix_data = (enable && src_valid) ? src_data : '0;
endmodule

// File: rtl/lcd_rgb_timing.sv
module lcd_rgb_timing
  import lcd_tim_pkg::*;
#(
  parameter int H_ACT   = 176,
  parameter int H_BP    = 10,
  parameter int H_FP    = 10,
  parameter int V_ACT   = 220,
  parameter int V_TOTAL = 224,
  parameter int VBP_W   = 8,
  parameter int CW      = 6,
  localparam int H_TOTAL = H_BP + H_ACT + H_FP,
  localparam int HW      = ctr_width(H_TOTAL),
  localparam int VW      = ctr_width(V_TOTAL),
  localparam int PW      = 3 * CW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VBP_W-1:0] vbp_cfg,
  input  logic             src_valid,
  input  logic [PW-1:0]    src_data,
  output logic             src_ready,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             enable,
  output logic [PW-1:0]    pix_data,
  output logic [HW-1:0]    h_count,
  output logic [VW-1:0]    v_count
);
  // Named internal events, used by the bound checker
  logic             h_wrap;
  logic             v_wrap;
  logic             h_act;
  logic             v_act;
  logic [VBP_W-1:0] vbp_q;

  lcd_wrap_ctr #(.LIMIT(H_TOTAL), .W(HW)) u_hctr (
    .clk   (clk),
    .rst   (rst),
    .inc   (1'b1),
    .count (h_count),
    .wrap  (h_wrap)
  );

  lcd_wrap_ctr #(.LIMIT(V_TOTAL), .W(VW)) u_vctr (
    .clk   (clk),
    .rst   (rst),
    .inc   (h_wrap),
    .count (v_count),
    .wrap  (v_wrap)
  );

  // Back porch is frozen for a whole frame
  always_ff @(posedge clk) begin
    if (rst || v_wrap) vbp_q <= vbp_cfg;
  end

  assign h_act     = in_span(int'(h_count), H_BP, H_ACT);
  assign v_act     = in_span(int'(v_count), int'(vbp_q), V_ACT);
  assign hsync_n   = (h_count != '0);
  assign vsync_n   = (v_count != '0);
  assign enable    = h_act && v_act;
  assign src_ready = enable;

  lcd_pixel_gate #(.PW(PW)) u_gate (
    .enable    (enable),
    .src_valid (src_valid),
    .src_data  (src_data),
    .pix_data  (pix_data)
  );
endmodule

// File: rtl/lcd_rgb_timing_chk.sv
module lcd_rgb_timing_chk #(
  parameter int H_ACT   = 176,
  parameter int H_BP    = 10,
  parameter int H_TOTAL = 196,
  parameter int V_ACT   = 220,
  parameter int V_TOTAL = 224,
  parameter int VBP_W   = 8,
  parameter int HW      = 8,
  parameter int VW      = 8,
  parameter int PW      = 18
) (
  input logic             clk,
  input logic             rst,
  input logic [HW-1:0]    h_count,
  input logic [VW-1:0]    v_count,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             enable,
  input logic [PW-1:0]    pix_data,
  input logic             v_wrap,
  input logic [VBP_W-1:0] vbp_q
);
  assert_hstep_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(h_count) != H_TOTAL - 1) |=> (int'(h_count) == int'($past(h_count)) + 1));

  assert_hwrap_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(h_count) == H_TOTAL - 1) |=> (h_count == '0));

  assert_vstep_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(h_count) == H_TOTAL - 1) |=>
      (int'(v_count) == ((int'($past(v_count)) == V_TOTAL - 1) ? 0 : int'($past(v_count)) + 1)));

  assert_vhold_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(h_count) != H_TOTAL - 1) |=> $stable(v_count));

  assert_hsync_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |=> hsync_n);

  assert_hsync_pos_R2: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> (h_count == '0));

  assert_vsync_pos_R3: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> (v_count == '0));

  assert_hwin_R4: assert property (@(posedge clk) disable iff (rst)
    enable |-> ((int'(h_count) >= H_BP) && (int'(h_count) < H_BP + H_ACT)));

  assert_vwin_R5: assert property (@(posedge clk) disable iff (rst)
    enable |-> ((int'(v_count) >= int'(vbp_q)) && (int'(v_count) < int'(vbp_q) + V_ACT)));

  assert_vbp_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !v_wrap |=> $stable(vbp_q));

  assert_blank_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (pix_data == '0));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> ((h_count == '0) && (v_count == '0) && !enable));
endmodule

bind lcd_rgb_timing lcd_rgb_timing_chk #(
  .H_ACT   (H_ACT),
  .H_BP    (H_BP),
  .H_TOTAL (H_TOTAL),
  .V_ACT   (V_ACT),
  .V_TOTAL (V_TOTAL),
  .VBP_W   (VBP_W),
  .HW      (HW),
  .VW      (VW),
  .PW      (PW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .h_count  (h_count),
  .v_count  (v_count),
  .hsync_n  (hsync_n),
  .vsync_n  (vsync_n),
  .enable   (enable),
  .pix_data (pix_data),
  .v_wrap   (v_wrap),
  .vbp_q    (vbp_q)
);

// File: tb/test_lcd_rgb_timing.sv
module test_lcd_rgb_timing;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  vbp_cfg = 8'd0;
  logic        src_valid = 1'b0;
  logic [17:0] src_data = '0;
  logic        src_ready, hsync_n, vsync_n, enable;
  logic [17:0] pix_data;
  logic [7:0]  h_count, v_count;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_rgb_timing i_lcd_rgb_timing (
    .clk(clk), .rst(rst), .vbp_cfg(vbp_cfg), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .enable(enable), .pix_data(pix_data),
    .h_count(h_count), .v_count(v_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bench raster model
  int  hm = 0, vm = 0, vbpm = 0;
  bit  model_ok = 1'b0;
  bit  just_reset = 1'b0;
  int  en_count = 0;
  int  frames = 0;
  int  frame_vbp = 0;

  function automatic int exp_lines(input int b);
    int last;
    last = (b + 220 < 224) ? b + 220 : 224;
    return (last > b) ? last - b : 0;
  endfunction

  initial begin
    for (int cyc = 0; cyc < 150000 && frames < 3; cyc++) begin
      @(negedge clk);
      if (model_ok) begin
        bit h_a, v_a, e;
        h_a = (hm >= 10) && (hm < 186);
        v_a = (vm >= vbpm) && (vm < vbpm + 220) && (vm < 224);
        e   = h_a && v_a;
        chk(just_reset ? "R9 h_count" : "R1 h_count", int'(h_count), hm);
        chk(just_reset ? "R9 v_count" : "R1 v_count", int'(v_count), vm);
        chk("R2 hsync_n", int'(hsync_n), (hm != 0) ? 1 : 0);
        chk("R3 vsync_n", int'(vsync_n), (vm != 0) ? 1 : 0);
        chk("R4 R5 R6 R7 enable", int'(enable), int'(e));
        chk("R7 src_ready", int'(src_ready), int'(e));
        chk("R8 pix_data", int'(pix_data), (e && src_valid) ? int'(src_data) : 0);
        if (enable) en_count++;
      end
      // next inputs
      if (cyc < 3) begin
        rst = 1'b1; vbp_cfg = 8'd0;
      end else if (cyc < 1000) begin
        rst = 1'b0;
      end else if (cyc < 1002) begin
        rst = 1'b1; vbp_cfg = 8'd3;
      end else begin
        rst = 1'b0;
        if (frames == 0 && vm == 100 && hm == 0) vbp_cfg = 8'd250;
        if (frames == 1 && vm == 50 && hm == 0)  vbp_cfg = 8'd10;
      end
      src_valid = ((cyc % 7) != 3);
      src_data  = 18'(cyc * 97 + 13);
      // model step for the coming edge
      if (rst) begin
        hm = 0; vm = 0; vbpm = int'(vbp_cfg);
        model_ok = 1'b1; just_reset = 1'b1;
        en_count = 0; frame_vbp = vbpm;
      end else begin
        just_reset = 1'b0;
        if (hm == 195) begin
          hm = 0;
          if (vm == 223) begin
            vm = 0;
            if (cyc >= 1002) begin
              // R5 R6: enabled clocks in the finished frame
              chk("R5 R6 frame enable count", en_count, 176 * exp_lines(frame_vbp));
              frames++;
            end
            en_count = 0;
            vbpm = int'(vbp_cfg);
            frame_vbp = vbpm;
          end else vm++;
        end else hm++;
      end
    end
    chk("R1 frames completed", frames, 3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 199000; w++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", frames, 3);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule